// File: doc/BRIEF.md
# Grid Affine Value Generator

This block hands every processing element of a two-dimensional SIMD array its own value of the form A·x + B·y + C, where x is the column of the element and y its row. Three coefficients are broadcast to the block once. After that the block walks the whole grid and emits one value per cycle, so each element can, for example, receive a distinct starting key for a search. The walk needs no multiplier. Moving one column to the right adds A to a running accumulator. Moving to a new row adds B to a per-row base, and the accumulator restarts from that base.

The result width is chosen per evaluation as 1, 2, 4 or 8 bytes. The arithmetic wraps at that width, and the bits above it read as zero. Each value leaves the block together with its column and row coordinates. A one-cycle completion flag follows the last element.

Top module: `affine_grid_eval`

## Requirements
- R1: While rst_ni is low and after its release, valid_o and done_o are low until a start is accepted.
- R2: A start_i pulse accepted while idle makes valid_o high on the next cycle, with col_o = 0, row_o = 0 and value_o = C truncated to the selected width.
- R3: Values are emitted in raster order, one per cycle. col_o advances by one each cycle. After col_o = COLS-1, col_o returns to 0 and row_o advances by one.
- R4: value_o = (A·col_o + B·row_o + C) mod 2^(8·N), and all bits from 8·N upward are zero. N is taken from width_sel_i with the code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R5: The coefficients and width_sel_i are sampled only in the cycle a start is accepted. Changing them during a sweep has no effect on the values emitted.
- R6: A start_i pulse that arrives while a sweep is in progress is ignored. The sweep continues without a restart of its coordinates or values.
- R7: A sweep emits exactly COLS·ROWS valid cycles. done_o is high for exactly the one cycle after element (COLS-1, ROWS-1), and valid_o is low in that cycle.
- R8: valid_o is low whenever no sweep is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; acted on only while idle |
| width_sel_i | input | 2 | Result width code: 0, 1, 2, 3 select 1, 2, 4, 8 bytes |
| coef_a_i | input | 64 | Column coefficient A |
| coef_b_i | input | 64 | Row coefficient B |
| coef_c_i | input | 64 | Constant term C |
| valid_o | output | 1 | value_o, col_o and row_o hold an element |
| value_o | output | 64 | Affine value of the current element, zero above the selected width |
| col_o | output | 7 | Column x of the current element |
| row_o | output | 6 | Row y of the current element |
| done_o | output | 1 | One-cycle pulse after the last element |

## Verification
The hardest behaviour to reach from the ports is a sweep that gets disturbed partway through. In that case a second start and new coefficients and width arrive mid-grid, and the accumulators must keep their state and ignore them. One sweep is run in which, a hundred elements in, the bench pulses start_i and drives fresh random coefficients and a different width. Every remaining value is then compared with the coefficients captured at launch. Narrow widths with all-ones coefficients push the accumulator through many wraps. A directed index pattern with A = 1 and B = COLS checks the raster numbering across every row boundary.

// File: rtl/affine_grid_pkg.sv
package affine_grid_pkg;
  localparam int unsigned BYTE_W = 8;

  // width code -> number of bytes
  function automatic int unsigned bytes_of(input int unsigned code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/affine_lane_mask.sv
module affine_lane_mask #(
  parameter int unsigned MAX_BYTES = 8,
  parameter int unsigned WSW       = 2,
  localparam int unsigned DW       = affine_grid_pkg::BYTE_W * MAX_BYTES
) (
  input  logic [DW-1:0]  data_i,
  input  logic [WSW-1:0] width_i,
  output logic [DW-1:0]  data_o
);
  import affine_grid_pkg::*;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    logic keep;
    assign keep = (g < bytes_of(32'(width_i)));
    assign data_o[g*BYTE_W +: BYTE_W] = keep ? data_i[g*BYTE_W +: BYTE_W] : '0;
  end
endmodule

// File: rtl/affine_coord_seq.sv
module affine_coord_seq #(
  parameter int unsigned COLS = 128,
  parameter int unsigned ROWS = 64,
  localparam int unsigned XW  = $clog2(COLS),
  localparam int unsigned YW  = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          launch_o,
  output logic          busy_o,
  output logic          step_x_o,
  output logic          step_y_o,
  output logic [XW-1:0] col_o,
  output logic [YW-1:0] row_o,
  output logic          done_o
);
  localparam logic [XW-1:0] XLAST = XW'(COLS - 1);
  localparam logic [YW-1:0] YLAST = YW'(ROWS - 1);

  logic          busy_q, done_q;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic          x_end, y_end;

  assign x_end    = (x_q == XLAST);
  assign y_end    = (y_q == YLAST);
  assign launch_o = start_i && !busy_q;
  assign step_x_o = busy_q && !x_end;
  assign step_y_o = busy_q && x_end && !y_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
    end else begin
      done_q <= busy_q && x_end && y_end;
      if (launch_o) begin
        busy_q <= 1'b1;
        x_q    <= '0;
        y_q    <= '0;
      end else if (busy_q) begin
        if (x_end) begin
          x_q <= '0;
          if (y_end) busy_q <= 1'b0;
          else       y_q    <= y_q + 1'b1;
        end else begin
          x_q <= x_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign col_o  = x_q;
  assign row_o  = y_q;
  assign done_o = done_q;
endmodule

// File: rtl/affine_accum.sv
module affine_accum #(
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          step_x_i,
  input  logic          step_y_i,
  input  logic [DW-1:0] coef_a_i,
  input  logic [DW-1:0] coef_b_i,
  input  logic [DW-1:0] coef_c_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] a_lat_o
);
  logic [DW-1:0] a_q, b_q, row_base_q, acc_q, next_base;

  assign next_base = row_base_q + b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q        <= '0;
      b_q        <= '0;
      row_base_q <= '0;
      acc_q      <= '0;
    end else if (launch_i) begin
      a_q        <= coef_a_i;
      b_q        <= coef_b_i;
      row_base_q <= coef_c_i;
      acc_q      <= coef_c_i;
    end else if (step_y_i) begin
      row_base_q <= next_base;
      acc_q      <= next_base;
    end else if (step_x_i) begin
      acc_q <= acc_q + a_q;
    end
  end

  assign acc_o   = acc_q;
  assign a_lat_o = a_q;
endmodule

// File: rtl/affine_grid_eval.sv
module affine_grid_eval #(
  parameter int unsigned COLS      = 128,
  parameter int unsigned ROWS      = 64,
  parameter int unsigned MAX_BYTES = 8,
  localparam int unsigned DW       = affine_grid_pkg::BYTE_W * MAX_BYTES,
  localparam int unsigned XW       = $clog2(COLS),
  localparam int unsigned YW       = $clog2(ROWS),
  localparam int unsigned WSW      = $clog2($clog2(MAX_BYTES) + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [WSW-1:0] width_sel_i,
  input  logic [DW-1:0]  coef_a_i,
  input  logic [DW-1:0]  coef_b_i,
  input  logic [DW-1:0]  coef_c_i,
  output logic           valid_o,
  output logic [DW-1:0]  value_o,
  output logic [XW-1:0]  col_o,
  output logic [YW-1:0]  row_o,
  output logic           done_o
);
  logic           launch, busy, step_x, step_y;
  logic [DW-1:0]  acc, a_lat;
  logic [WSW-1:0] w_q;

  affine_coord_seq #(.COLS(COLS), .ROWS(ROWS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .launch_o (launch),
    .busy_o   (busy),
    .step_x_o (step_x),
    .step_y_o (step_y),
    .col_o    (col_o),
    .row_o    (row_o),
    .done_o   (done_o)
  );

  affine_accum #(.DW(DW)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .step_x_i (step_x),
    .step_y_i (step_y),
    .coef_a_i (coef_a_i),
    .coef_b_i (coef_b_i),
    .coef_c_i (coef_c_i),
    .acc_o    (acc),
    .a_lat_o  (a_lat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     w_q <= '0;
    else if (launch) w_q <= width_sel_i;
  end

  affine_lane_mask #(.MAX_BYTES(MAX_BYTES), .WSW(WSW)) u_mask (
    .data_i  (acc),
    .width_i (w_q),
    .data_o  (value_o)
  );

  assign valid_o = busy;
endmodule

// File: rtl/affine_grid_eval_chk.sv
module affine_grid_eval_chk #(
  parameter int unsigned COLS = 128,
  parameter int unsigned ROWS = 64,
  parameter int unsigned DW   = 64,
  parameter int unsigned XW   = 7,
  parameter int unsigned YW   = 6,
  parameter int unsigned WSW  = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           valid_o,
  input logic [DW-1:0]  value_o,
  input logic [XW-1:0]  col_o,
  input logic [YW-1:0]  row_o,
  input logic           done_o,
  input logic [WSW-1:0] w_q,
  input logic [DW-1:0]  a_lat
);
  function automatic logic [DW-1:0] width_mask(input logic [WSW-1:0] w);
    int unsigned bits;
    bits = 8 << w;
    if (bits >= DW) return '1;
    return (DW'(1) << bits) - DW'(1);
  endfunction

  logic last_elem;
  assign last_elem = valid_o && (col_o == XW'(COLS - 1)) && (row_o == YW'(ROWS - 1));

  // R2
  start_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_o |=> valid_o && col_o == '0 && row_o == '0);

  // R3
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && col_o != XW'(COLS - 1) |=> valid_o && col_o == $past(col_o) + 1'b1 && row_o == $past(row_o));

  // R3
  row_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && col_o == XW'(COLS - 1) && row_o != YW'(ROWS - 1) |=> valid_o && col_o == '0 && row_o == $past(row_o) + 1'b1);

  // R4
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (value_o & ~width_mask(w_q)) == '0);

  // R4
  x_step_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && col_o != XW'(COLS - 1) |=> value_o == (($past(value_o) + a_lat) & width_mask(w_q)));

  // R6
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_elem |=> valid_o);

  // R7
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_elem |=> done_o && !valid_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);
endmodule

bind affine_grid_eval affine_grid_eval_chk #(
  .COLS(COLS), .ROWS(ROWS), .DW(DW), .XW(XW), .YW(YW), .WSW(WSW)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .valid_o (valid_o),
  .value_o (value_o),
  .col_o   (col_o),
  .row_o   (row_o),
  .done_o  (done_o),
  .w_q     (w_q),
  .a_lat   (a_lat)
);

// File: tb/affine_grid_eval_tb_top.sv
module affine_grid_eval_tb_top;
  localparam int unsigned COLS = 128;
  localparam int unsigned ROWS = 64;
  localparam int unsigned DW   = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    wsel = '0;
  logic [DW-1:0] ca = '0, cb = '0, cc = '0;
  logic          valid, done;
  logic [DW-1:0] value;
  logic [6:0]    col;
  logic [5:0]    row;

  int unsigned n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  affine_grid_eval dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .width_sel_i(wsel),
    .coef_a_i(ca), .coef_b_i(cb), .coef_c_i(cc),
    .valid_o(valid), .value_o(value), .col_o(col), .row_o(row), .done_o(done)
  );

  function automatic logic [DW-1:0] ref_val(input logic [DW-1:0] a, b, c,
                                            input logic [1:0] w, input int x, y);
    logic [DW-1:0] r, m;
    r = a * DW'(x) + b * DW'(y) + c;
    m = (w == 2'd3) ? '1 : ((DW'(1) << (8 << w)) - DW'(1));
    return r & m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep(input logic [DW-1:0] a, b, c, input logic [1:0] w, input bit disturb);
    int bad;
    bad = 0;
    ca = a; cb = b; cc = c; wsel = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 first element
    check(valid && col == 0 && row == 0, "R2", value, ref_val(a, b, c, w, 0, 0));
    for (int k = 0; k < COLS * ROWS; k++) begin
      int x, y;
      x = k % COLS; y = k / COLS;
      // R3 raster order, R8 valid through sweep
      check(valid && col == 7'(x) && row == 6'(y), "R3", {col, row}, {7'(x), 6'(y)});
      // R4 value and width; R5/R6 under disturbance
      check(value == ref_val(a, b, c, w, x, y), disturb ? "R5 R6" : "R4",
            value, ref_val(a, b, c, w, x, y));
      check(!done, "R7", done, 0);
      if (disturb && k == 100) begin
        ca = $urandom; cb = {$urandom, $urandom}; cc = {$urandom, $urandom};
        wsel = w ^ 2'b01; start = 1'b1;
      end
      if (disturb && k == 101) start = 1'b0;
      @(negedge clk);
    end
    // R7 done pulse after last element
    check(done && !valid, "R7", {done, valid}, 2'b10);
    @(negedge clk);
    check(!done && !valid, "R7", {done, valid}, 2'b00);
    // R8 idle stays idle
    @(negedge clk);
    check(!valid, "R8", valid, 0);
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    // R1 reset state
    #1;
    check(!valid && !done, "R1", {valid, done}, 2'b00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid && !done, "R1", {valid, done}, 2'b00);
    sweep(64'd1, 64'(COLS), 64'd0, 2'd3, 1'b0);
    sweep('1, '1, 64'hff, 2'd0, 1'b0);
    sweep({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 2'd1, 1'b1);
    sweep({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 2'd2, 1'b0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule